// File: doc/BRIEF.md
# Counter Timebase and Mode Control

This block is the timebase of a programmable counter array. A free-running 16-bit counter advances by one on each count enable from a source picked by a 3-bit select field: the system clock divided by 12 or by 4, every system clock, a one-cycle timer overflow pulse, falling edges on an external count pin, or an external clock divided by 8. Both external pins are synchronised into the system clock domain before any enable is produced. When the counter wraps, a sticky overflow flag is set. The flag drives the interrupt output when the overflow interrupt enable is on.

An 8-bit mode register holds the source select, an idle-hold bit that suspends counting while the processor idles, the overflow interrupt enable, a watchdog enable and a watchdog lock. The register comes out of reset with the watchdog enabled. While that enable is set, the register protects itself: a write can only clear the enable, and only if the lock is not set. Software reaches everything through a 2-bit address, byte-wide register port with combinational read data.

Top module: `ctb_timebase`

## Requirements
- R1: After reset the mode register reads 0x40, the status register reads 0x00, the counter reads 0x0000 and irq_o is 0.
- R2: Mode bits [3:1] select the source. Code 000 advances the counter once per 12 system clocks and code 001 once per 4, each from a free-running prescaler.
- R3: Code 100 advances the counter on every system clock. Each count enable adds exactly one.
- R4: Code 010 advances the counter once for each cycle in which tmr_ovf_i is high.
- R5: Code 011 advances the counter once for each high-to-low transition of ext_cnt_i, after a two-flop synchroniser, at rates up to one transition per 4 system clocks. Low-to-high transitions do not count.
- R6: Code 101 advances the counter once for every 8 synchronised rising edges of ext_clk_i.
- R7: Codes 110 and 111 produce no count enable, so the counter holds its value.
- R8: When mode bit 7 (idle hold) is 1 and idle_i is 1, the counter does not advance. When bit 7 is 0, idle_i has no effect.
- R9: A wrap from 0xFFFF to 0x0000 sets the overflow flag, status bit 0. The flag stays set until a status write with bit 0 equal to 0. Writing 1 to it has no effect.
- R10: irq_o is 1 exactly when the overflow flag is 1 and mode bit 0 (overflow interrupt enable) is 1.
- R11: While mode bit 6 (watchdog enable) is 1, a mode write leaves bits 7 and 5..0 unchanged. Such a write can only clear bit 6.
- R12: Mode bit 5 (lock) can be set by a write made while the watchdog is disabled, and only a reset clears it. While bits 6 and 5 are both 1, bit 6 cannot be cleared.
- R13: Mode bit 4 always reads 0, whatever value is written to it.
- R14: Address 0 is the mode register, 1 the status register, 2 the counter low byte and 3 the counter high byte. A write to address 2 or 3 loads that byte, and a load takes precedence over a count enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| idle_i | input | 1 | Processor idle indication |
| tmr_ovf_i | input | 1 | Timer overflow pulse, one cycle per event |
| ext_cnt_i | input | 1 | External count pin, asynchronous |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench sweeps all eight select codes against all four combinations of idle hold and idle, and compares the counter advance over a 48-cycle window with a count worked out from the division ratios. A prescaler off by one, a reserved code that still counts, or a suspend that ignores the hold bit would each give a wrong advance. The external pins are driven at the fastest supported rate and with lone rising edges, and partial groups of external clock edges are sent, so a rising-edge detector or a divide-by-7 would show up as a wrong count. The register tests write all-ones, clear-only and lock patterns while the watchdog is enabled, reload the counter to just below the wrap point and follow the flag and interrupt cycle by cycle. A protection leak, a lock that can be cleared, or a flag that clears itself would each show up.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

  typedef enum logic [2:0] {
    SRC_DIV12   = 3'd0,
    SRC_DIV4    = 3'd1,
    SRC_TOVF    = 3'd2,
    SRC_EXTFALL = 3'd3,
    SRC_SYSCLK  = 3'd4,
    SRC_EXTDIV  = 3'd5,
    SRC_RSV6    = 3'd6,
    SRC_RSV7    = 3'd7
  } src_e;

  typedef struct packed {
    logic       idle_hold;
    logic       wd_en;
    logic       wd_lock;
    logic       zero4;
    logic [2:0] src;
    logic       ovf_ie;
  } mode_t;

  localparam logic [7:0] MODE_RST = 8'h40;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CLO  = 2'd2;
  localparam logic [1:0] ADDR_CHI  = 2'd3;

  // Next mode register value for a software write.
  function automatic mode_t mode_update(mode_t cur, logic [7:0] wd);
    mode_t nxt;
    nxt = cur;
    if (cur.wd_en) begin
      if (!wd[6] && !cur.wd_lock) nxt.wd_en = 1'b0;
    end else begin
      nxt = mode_t'(wd);
      nxt.wd_lock = wd[5] | cur.wd_lock;
    end
    nxt.zero4 = 1'b0;
    return nxt;
  endfunction

  // Source code that can never produce a count enable.
  function automatic logic src_reserved(logic [2:0] s);
    return s[2] & s[1];
  endfunction

endpackage

// File: rtl/ctb_prescaler.sv
module ctb_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic pulse_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (at_end) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign pulse_o = at_end;
endmodule

// File: rtl/ctb_sync_edge.sv
module ctb_sync_edge #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES:0] sh_q;
  logic            lvl_new;
  logic            lvl_old;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign lvl_new = sh_q[STAGES-1];
  assign lvl_old = sh_q[STAGES];

  generate
    if (FALLING) begin : g_fall
      assign edge_o = lvl_old & ~lvl_new;
    end else begin : g_rise
      assign edge_o = lvl_new & ~lvl_old;
    end
  endgenerate
endmodule

// File: rtl/ctb_pulse_div.sv
module ctb_pulse_div #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_pulse,
  output logic out_pulse
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (in_pulse) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  assign out_pulse = in_pulse & last;
endmodule

// File: rtl/ctb_timebase.sv
module ctb_timebase
  import ctb_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_SLOW    = 12,
  parameter int PRE_FAST    = 4,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       idle_i,
  input  logic       tmr_ovf_i,
  input  logic       ext_cnt_i,
  input  logic       ext_clk_i,
  output logic       irq_o
);
  localparam int HI_W = CNT_W - 8;

  mode_t            mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  logic wr_mode, wr_stat, wr_lo, wr_hi, wr_cnt;
  logic p_slow, p_fast, p_fall, p_rise, p_extdiv;
  logic src_pulse, suspend, tick, ovf_evt;

  assign wr_mode = reg_we && (reg_addr == ADDR_MODE);
  assign wr_stat = reg_we && (reg_addr == ADDR_STAT);
  assign wr_lo   = reg_we && (reg_addr == ADDR_CLO);
  assign wr_hi   = reg_we && (reg_addr == ADDR_CHI);
  assign wr_cnt  = wr_lo | wr_hi;

  ctb_prescaler #(.DIV(PRE_SLOW)) u_pre_slow (
    .clk(clk), .rst_n(rst_n), .pulse_o(p_slow));

  ctb_prescaler #(.DIV(PRE_FAST)) u_pre_fast (
    .clk(clk), .rst_n(rst_n), .pulse_o(p_fast));

  ctb_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_cnt_i), .edge_o(p_fall));

  ctb_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_clk_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_clk_i), .edge_o(p_rise));

  ctb_pulse_div #(.DIV(EXT_DIV)) u_ext_div (
    .clk(clk), .rst_n(rst_n), .in_pulse(p_rise), .out_pulse(p_extdiv));

  always_comb begin
    case (src_e'(mode_q.src))
      SRC_DIV12:   src_pulse = p_slow;
      SRC_DIV4:    src_pulse = p_fast;
      SRC_TOVF:    src_pulse = tmr_ovf_i;
      SRC_EXTFALL: src_pulse = p_fall;
      SRC_SYSCLK:  src_pulse = 1'b1;
      SRC_EXTDIV:  src_pulse = p_extdiv;
      default:     src_pulse = 1'b0;
    endcase
  end

  assign suspend = mode_q.idle_hold & idle_i;
  assign tick    = src_pulse & ~suspend & ~src_reserved(mode_q.src);
  assign ovf_evt = tick & ~wr_cnt & (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= mode_t'(MODE_RST);
    else if (wr_mode) mode_q <= mode_update(mode_q, reg_wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      if (wr_lo) cnt_q[7:0]       <= reg_wdata;
      if (wr_hi) cnt_q[CNT_W-1:8] <= reg_wdata[HI_W-1:0];
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      flag_q <= 1'b0;
    else if (ovf_evt)                flag_q <= 1'b1;
    else if (wr_stat && !reg_wdata[0]) flag_q <= 1'b0;
  end

  assign irq_o = flag_q & mode_q.ovf_ie;

  always_comb begin
    case (reg_addr)
      ADDR_MODE: reg_rdata = mode_q;
      ADDR_STAT: reg_rdata = {7'd0, flag_q};
      ADDR_CLO:  reg_rdata = cnt_q[7:0];
      default:   reg_rdata = 8'(cnt_q[CNT_W-1:8]);
    endcase
  end
endmodule

// File: rtl/ctb_timebase_chk.sv
module ctb_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ovf_evt,
  input logic             wr_cnt,
  input logic             wr_stat,
  input logic             wr_mode,
  input logic [7:0]       wdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic             flag_q,
  input logic [7:0]       mode_bits,
  input logic             idle_i,
  input logic             irq_o
);
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt_q));

  // R7
  rsv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits[3:2] == 2'b11) |-> !tick);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits[7] && idle_i) |-> !tick);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag_q);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_stat && !wdata[0])) |=> flag_q);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_q && mode_bits[0]));

  // R11
  wd_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits[6] && wr_mode) |=>
      (mode_bits[7] == $past(mode_bits[7]) && mode_bits[5:0] == $past(mode_bits[5:0])));

  // R12
  wd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits[6] && mode_bits[5]) |=> mode_bits[6]);

  // R13
  zero_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> !mode_bits[4]);
endmodule

bind ctb_timebase ctb_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ovf_evt(ovf_evt), .wr_cnt(wr_cnt),
  .wr_stat(wr_stat), .wr_mode(wr_mode), .wdata(reg_wdata), .cnt_q(cnt_q),
  .flag_q(flag_q), .mode_bits(mode_q), .idle_i(idle_i), .irq_o(irq_o));

// File: tb/ctb_timebase_tb.sv
`timescale 1ns/1ps
module ctb_timebase_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       idle_i = 1'b0;
  logic       tmr_ovf_i = 1'b0;
  logic       ext_cnt_i = 1'b1;
  logic       ext_clk_i = 1'b0;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctb_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .idle_i(idle_i),
    .tmr_ovf_i(tmr_ovf_i), .ext_cnt_i(ext_cnt_i), .ext_clk_i(ext_clk_i),
    .irq_o(irq_o));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] c);
    logic [7:0] lo, hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    c = {hi, lo};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int exp_adv(int src, bit hold, bit idl, int m);
    if (hold && idl) return 0;
    case (src)
      0: return m / 12;
      1: return m / 4;
      4: return m;
      default: return 0;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] c0, c1;

    do_reset();
    // R1 reset state
    rd(2'd0, b); check("R1", "mode after reset", b, 8'h40);
    rd(2'd1, b); check("R1", "status after reset", b, 8'h00);
    rd_cnt(c0);  check("R1", "count after reset", c0, 16'h0000);
    check("R1", "irq after reset", irq_o, 1'b0);

    // R11 protection while watchdog enabled
    wr(2'd0, 8'hFF); rd(2'd0, b); check("R11", "all-ones write under watchdog", b, 8'h40);
    wr(2'd0, 8'hBF); rd(2'd0, b); check("R11", "clear-only write", b, 8'h00);
    // R13 bit 4 reads zero
    wr(2'd0, 8'h10); rd(2'd0, b); check("R13", "bit4 write", b, 8'h00);
    wr(2'd0, 8'h1D); rd(2'd0, b); check("R13", "bit4 with others", b, 8'h0D);

    // R14 counter load, R7 reserved codes hold
    wr(2'd0, 8'h0C);
    wr(2'd2, 8'h34); wr(2'd3, 8'h12);
    rd_cnt(c0); check("R14", "count load", c0, 16'h1234);
    repeat (20) @(negedge clk);
    rd_cnt(c0); check("R7", "code 110 holds", c0, 16'h1234);
    wr(2'd0, 8'h0E);
    repeat (20) @(negedge clk);
    rd_cnt(c0); check("R7", "code 111 holds", c0, 16'h1234);

    // Sweep: R2 R3 R7 R8
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 4; k++) begin
        bit hold, idl;
        string tg;
        hold = k[1]; idl = k[0];
        @(negedge clk); idle_i = idl;
        wr(2'd0, {hold, 3'b000, 3'(s), 1'b0});
        rd_cnt(c0);
        repeat (48) @(posedge clk);
        @(negedge clk);
        rd_cnt(c1);
        if (hold && idl)            tg = "R8";
        else if (s == 0 || s == 1)  tg = "R2";
        else if (s == 4)            tg = "R3";
        else if (s >= 6)            tg = "R7";
        else                        tg = "R8";
        check(tg, $sformatf("advance src%0d hold%0d idle%0d", s, hold, idl),
              32'(c1 - c0), 32'(exp_adv(s, hold, idl, 48)));
      end
    end
    @(negedge clk); idle_i = 1'b0;

    // R4 timer overflow pulses
    wr(2'd0, 8'h04);
    rd_cnt(c0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); tmr_ovf_i = 1'b1;
      @(negedge clk); tmr_ovf_i = 1'b0;
      repeat (i % 3) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    rd_cnt(c1); check("R4", "timer pulses", 32'(c1 - c0), 32'd7);

    // R5 falling edges on external count pin
    wr(2'd0, 8'h06);
    rd_cnt(c0);
    @(negedge clk); ext_cnt_i = 1'b0;
    repeat (6) @(negedge clk);
    rd_cnt(c1); check("R5", "single fall", 32'(c1 - c0), 32'd1);
    @(negedge clk); ext_cnt_i = 1'b1;
    repeat (6) @(negedge clk);
    rd_cnt(c1); check("R5", "rise ignored", 32'(c1 - c0), 32'd1);
    rd_cnt(c0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ext_cnt_i = 1'b0;
      @(negedge clk);
      @(negedge clk); ext_cnt_i = 1'b1;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
    rd_cnt(c1); check("R5", "falls at quarter rate", 32'(c1 - c0), 32'd5);

    // R6 external clock divided by 8
    wr(2'd0, 8'h0A);
    rd_cnt(c0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); ext_clk_i = 1'b1;
      @(negedge clk);
      @(negedge clk); ext_clk_i = 1'b0;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
    rd_cnt(c1); check("R6", "16 edges", 32'(c1 - c0), 32'd2);
    rd_cnt(c0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ext_clk_i = 1'b1;
      @(negedge clk);
      @(negedge clk); ext_clk_i = 1'b0;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
    rd_cnt(c1); check("R6", "3 edges", 32'(c1 - c0), 32'd0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ext_clk_i = 1'b1;
      @(negedge clk);
      @(negedge clk); ext_clk_i = 1'b0;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
    rd_cnt(c1); check("R6", "8th edge", 32'(c1 - c0), 32'd1);

    // R9 R10 overflow flag and interrupt
    wr(2'd0, 8'h0C);
    wr(2'd2, 8'hFE); wr(2'd3, 8'hFF);
    rd_cnt(c0); check("R14", "load near wrap", c0, 16'hFFFE);
    wr(2'd0, 8'h08);
    rd_cnt(c0); check("R3", "no step before next edge", c0, 16'hFFFE);
    @(negedge clk);
    rd_cnt(c0); check("R3", "one step", c0, 16'hFFFF);
    rd(2'd1, b); check("R9", "flag before wrap", b, 8'h00);
    @(negedge clk);
    rd_cnt(c0); check("R9", "wrapped value", c0, 16'h0000);
    rd(2'd1, b); check("R9", "flag at wrap", b, 8'h01);
    check("R10", "irq masked", irq_o, 1'b0);
    wr(2'd1, 8'h01); rd(2'd1, b); check("R9", "write 1 keeps flag", b, 8'h01);
    wr(2'd0, 8'h09); #0.5; check("R10", "irq enabled", irq_o, 1'b1);
    repeat (10) @(negedge clk);
    rd(2'd1, b); check("R9", "flag sticky", b, 8'h01);
    wr(2'd1, 8'h00); #0.5;
    rd(2'd1, b); check("R9", "flag cleared", b, 8'h00);
    check("R10", "irq after clear", irq_o, 1'b0);

    // R12 lock
    wr(2'd0, 8'h20); rd(2'd0, b); check("R12", "lock set alone", b, 8'h20);
    wr(2'd0, 8'h00); rd(2'd0, b); check("R12", "lock sticky", b, 8'h20);
    wr(2'd0, 8'h40); rd(2'd0, b); check("R12", "enable with lock", b, 8'h60);
    wr(2'd0, 8'h00); rd(2'd0, b); check("R12", "locked enable holds", b, 8'h60);
    wr(2'd0, 8'h8F); rd(2'd0, b); check("R11", "locked protect", b, 8'h60);
    do_reset();
    rd(2'd0, b); check("R12", "reset clears lock", b, 8'h40);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule